// File: doc/BRIEF.md
# Configurable Quadrature Input Decoder

This block sits between the pins of an incremental encoder and a position counter. It takes two channel inputs, A and B, and turns them into a single-cycle count pulse and a direction level. Before any decoding, each channel can be inverted on its own, and the two channels can be exchanged. Two auxiliary inputs, index and strobe, get the same per-input inversion and the same synchroniser. They are then passed to the outputs aligned with the count pulse, without being interpreted.

A two-bit mode input picks one of four ways to decode the channels:
- Quadrature mode: both channels carry 90-degree shifted square waves, and every edge on either channel is one count.
- Clock-plus-direction mode: A is a count clock and B gives the direction level.
- Up mode and down mode: rising edges of A count in a fixed direction.

In quadrature mode, a jump in which both channels change within one sampled cycle cannot be resolved. It gives no count and raises a sticky error flag. A clear strobe resets that flag.

Top module: `qdec_front`

## Requirements
- R1: The mode input encodes 0 as quadrature, 1 as clock-plus-direction, 2 as up and 3 as down. All conditioning (inversion, swap) is applied ahead of the two-flop synchroniser.
- R2: In quadrature mode every single-channel transition yields one count pulse. The Gray sequence AB = 00,10,11,01 (A leading) counts up (dir=1), and the reverse sequence counts down (dir=0).
- R3: In quadrature mode a sampled step in which A and B both change gives no count and sets phase_err. phase_err stays set until err_clr is high at a clock edge, and a new error at the same edge takes precedence over the clear.
- R4: In clock-plus-direction mode with rise_only=0, both edges of A count, and dir takes the synchronised level of B (1 = up).
- R5: In clock-plus-direction mode with rise_only=1, only rising edges of A count.
- R6: In up mode only rising edges of A count, with dir=1. B has no effect on count_en or dir.
- R7: In down mode only rising edges of A count, with dir=0.
- R8: inv_a, inv_b, inv_idx and inv_stb each invert their own pin before synchronisation. Changing an invert control is therefore seen as an edge on that input.
- R9: swap_ab exchanges the conditioned A and B channels, so a pin sequence that counts up counts down when swap_ab=1.
- R10: count_en, dir, idx_out and stb_out change on the third rising clock edge after the pin change: two synchroniser stages and one output register. idx_out and stb_out equal the conditioned index and strobe pins.
- R11: During reset count_en=0, dir=1, phase_err=0, idx_out=0 and stb_out=0.
- R12: dir holds its last value on cycles with no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_a | input | 1 | Encoder channel A |
| pin_b | input | 1 | Encoder channel B |
| pin_idx | input | 1 | Index input |
| pin_stb | input | 1 | Strobe input |
| inv_a | input | 1 | Invert channel A |
| inv_b | input | 1 | Invert channel B |
| inv_idx | input | 1 | Invert index |
| inv_stb | input | 1 | Invert strobe |
| swap_ab | input | 1 | Exchange A and B |
| mode | input | 2 | Decode mode (0 quad, 1 clock/dir, 2 up, 3 down) |
| rise_only | input | 1 | Count rising A edges only in clock/dir mode |
| err_clr | input | 1 | Clear the phase error flag |
| count_en | output | 1 | One-cycle count pulse |
| dir | output | 1 | Count direction, 1 = up |
| phase_err | output | 1 | Sticky illegal-transition flag |
| idx_out | output | 1 | Conditioned, synchronised index |
| stb_out | output | 1 | Conditioned, synchronised strobe |

## Verification
The direction checks for the up and down modes rely on the mode input being unchanged for at least one cycle before the count pulse they inspect. The pass-through check assumes that index and strobe are low during reset, so that the synchroniser's reset contents match the pins. The stimulus meets both conditions: all pins are held low through reset, and mode, rise_only and swap are changed only while every pin has been steady long enough for the pipeline to hold no pending edge.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  localparam int N_CH       = 4;
  localparam int CH_A       = 0;
  localparam int CH_B       = 1;
  localparam int CH_IDX     = 2;
  localparam int CH_STB     = 3;
  localparam int SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    MODE_QUAD   = 2'd0,
    MODE_DIRCLK = 2'd1,
    MODE_UP     = 2'd2,
    MODE_DOWN   = 2'd3
  } mode_e;

  typedef struct packed {
    logic cnt;
    logic up;
    logic err;
  } step_t;

  // Quadrature step: one changed channel is a count, two is an error.
  function automatic step_t quad_step(input logic pa, input logic pb,
                                      input logic ca, input logic cb);
    step_t r;
    logic  da, db;
    da = pa ^ ca;
    db = pb ^ cb;
    r  = '0;
    if (da && db) begin
      r.err = 1'b1;
    end else if (da) begin
      r.cnt = 1'b1;
      r.up  = ca ^ cb;
    end else if (db) begin
      r.cnt = 1'b1;
      r.up  = ~(ca ^ cb);
    end
    return r;
  endfunction

  // Clock-plus-direction step: A edges count, B level is the direction.
  function automatic step_t clkdir_step(input logic pa, input logic ca,
                                        input logic cb, input logic rise);
    step_t r;
    r     = '0;
    r.up  = cb;
    r.cnt = rise ? (~pa & ca) : (pa ^ ca);
    return r;
  endfunction

  // Fixed-direction step: rising A only.
  function automatic step_t fixed_step(input logic pa, input logic ca,
                                       input logic up);
    step_t r;
    r     = '0;
    r.up  = up;
    r.cnt = ~pa & ca;
    return r;
  endfunction

endpackage

// File: rtl/qdec_cond.sv
module qdec_cond
  import qdec_pkg::*;
#(
  parameter int STAGES = SYNC_DEPTH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] raw,
  input  logic [N_CH-1:0] inv,
  input  logic            swap,
  output logic [N_CH-1:0] synced
);

  logic [N_CH-1:0] polar;
  logic [N_CH-1:0] cond;

  assign polar = raw ^ inv;

  always_comb begin
    cond = polar;
    if (swap) begin
      cond[CH_A] = polar[CH_B];
      cond[CH_B] = polar[CH_A];
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], cond[ch]};
    end
    assign synced[ch] = chain[STAGES-1];
  end

endmodule

// File: rtl/qdec_core.sv
module qdec_core
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cur_a,
  input  logic       cur_b,
  input  logic [1:0] mode,
  input  logic       rise_only,
  input  logic       err_clr,
  output logic       count_en,
  output logic       dir,
  output logic       phase_err,
  output logic       a_rise,
  output logic       both_chg
);

  logic  prev_a, prev_b;
  step_t step;

  assign a_rise   = ~prev_a & cur_a;
  assign both_chg = (prev_a ^ cur_a) & (prev_b ^ cur_b);

  always_comb begin
    unique case (mode_e'(mode))
      MODE_QUAD:   step = quad_step(prev_a, prev_b, cur_a, cur_b);
      MODE_DIRCLK: step = clkdir_step(prev_a, cur_a, cur_b, rise_only);
      MODE_UP:     step = fixed_step(prev_a, cur_a, 1'b1);
      default:     step = fixed_step(prev_a, cur_a, 1'b0);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a    <= 1'b0;
      prev_b    <= 1'b0;
      count_en  <= 1'b0;
      dir       <= 1'b1;
      phase_err <= 1'b0;
    end else begin
      prev_a   <= cur_a;
      prev_b   <= cur_b;
      count_en <= step.cnt;
      if (step.cnt) dir <= step.up;
      if (step.err)     phase_err <= 1'b1;
      else if (err_clr) phase_err <= 1'b0;
    end
  end

endmodule

// File: rtl/qdec_front.sv
module qdec_front
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_a,
  input  logic       pin_b,
  input  logic       pin_idx,
  input  logic       pin_stb,
  input  logic       inv_a,
  input  logic       inv_b,
  input  logic       inv_idx,
  input  logic       inv_stb,
  input  logic       swap_ab,
  input  logic [1:0] mode,
  input  logic       rise_only,
  input  logic       err_clr,
  output logic       count_en,
  output logic       dir,
  output logic       phase_err,
  output logic       idx_out,
  output logic       stb_out
);

  logic [N_CH-1:0] raw_vec, inv_vec, syn_vec;
  logic            a_rise_w, both_chg_w;

  assign raw_vec = {pin_stb, pin_idx, pin_b, pin_a};
  assign inv_vec = {inv_stb, inv_idx, inv_b, inv_a};

  qdec_cond #(.STAGES(SYNC_DEPTH)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (raw_vec),
    .inv    (inv_vec),
    .swap   (swap_ab),
    .synced (syn_vec)
  );

  qdec_core u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_a     (syn_vec[CH_A]),
    .cur_b     (syn_vec[CH_B]),
    .mode      (mode),
    .rise_only (rise_only),
    .err_clr   (err_clr),
    .count_en  (count_en),
    .dir       (dir),
    .phase_err (phase_err),
    .a_rise    (a_rise_w),
    .both_chg  (both_chg_w)
  );

  // Align index and strobe with the registered count pulse.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_out <= 1'b0;
      stb_out <= 1'b0;
    end else begin
      idx_out <= syn_vec[CH_IDX];
      stb_out <= syn_vec[CH_STB];
    end
  end

endmodule

// File: rtl/qdec_front_chk.sv
module qdec_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_idx,
  input logic       inv_idx,
  input logic       pin_stb,
  input logic       inv_stb,
  input logic [1:0] mode,
  input logic       err_clr,
  input logic       count_en,
  input logic       dir,
  input logic       phase_err,
  input logic       idx_out,
  input logic       stb_out,
  input logic       a_rise_w,
  input logic       both_chg_w
);

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_up_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && $past(mode) == 2'd2) |-> dir);

  assert_up_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && $past(mode) == 2'd2) |-> $past(a_rise_w));

  assert_down_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && $past(mode) == 2'd3) |-> !dir);

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_err && !err_clr) |=> phase_err);

  assert_err_no_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase_err) |-> !count_en);

  assert_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (both_chg_w && mode == 2'd0) |=> (phase_err && !count_en));

  assert_idx_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (idx_out == $past(pin_idx ^ inv_idx, 3)));

  assert_stb_lat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (stb_out == $past(pin_stb ^ inv_stb, 3)));

endmodule

bind qdec_front qdec_front_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_idx    (pin_idx),
  .inv_idx    (inv_idx),
  .pin_stb    (pin_stb),
  .inv_stb    (inv_stb),
  .mode       (mode),
  .err_clr    (err_clr),
  .count_en   (count_en),
  .dir        (dir),
  .phase_err  (phase_err),
  .idx_out    (idx_out),
  .stb_out    (stb_out),
  .a_rise_w   (a_rise_w),
  .both_chg_w (both_chg_w)
);

// File: tb/qdec_front_tb.sv
`timescale 1ns/1ps
module qdec_front_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_a = 0, pin_b = 0, pin_idx = 0, pin_stb = 0;
  logic inv_a = 0, inv_b = 0, inv_idx = 0, inv_stb = 0;
  logic swap_ab = 0, rise_only = 0, err_clr = 0;
  logic [1:0] mode = 2'd0;
  logic count_en, dir, phase_err, idx_out, stb_out;

  always #4 clk = ~clk;

  qdec_front u_dut (
    .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
    .pin_idx(pin_idx), .pin_stb(pin_stb), .inv_a(inv_a), .inv_b(inv_b),
    .inv_idx(inv_idx), .inv_stb(inv_stb), .swap_ab(swap_ab), .mode(mode),
    .rise_only(rise_only), .err_clr(err_clr), .count_en(count_en),
    .dir(dir), .phase_err(phase_err), .idx_out(idx_out), .stb_out(stb_out)
  );

  typedef struct {
    int    due;
    logic  cnt;
    logic  up;
    logic  idx;
    logic  stb;
    string req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  // Shadow configuration, applied to the pins inside drive().
  logic g_inv_a = 0, g_inv_b = 0, g_inv_idx = 0, g_inv_stb = 0;
  logic g_swap = 0, g_rise = 0;
  logic [1:0] g_mode = 2'd0;
  // Reference state.
  logic m_a = 0, m_b = 0, m_dir = 1;
  logic c_a = 0, c_b = 0, c_i = 0, c_s = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int gray_pos(input logic a, input logic b);
    case ({a, b})
      2'b00:   return 0;
      2'b10:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  task automatic drive(input logic a, input logic b, input logic i,
                       input logic s, input string req);
    logic ea, eb, cnt, up;
    int   d;
    @(negedge clk);
    inv_a = g_inv_a; inv_b = g_inv_b; inv_idx = g_inv_idx; inv_stb = g_inv_stb;
    swap_ab = g_swap; rise_only = g_rise; mode = g_mode;
    pin_a = a; pin_b = b; pin_idx = i; pin_stb = s;
    c_a = a; c_b = b; c_i = i; c_s = s;
    ea = g_swap ? (b ^ g_inv_b) : (a ^ g_inv_a);
    eb = g_swap ? (a ^ g_inv_a) : (b ^ g_inv_b);
    cnt = 1'b0; up = m_dir;
    case (g_mode)
      2'd0: begin
        d = (gray_pos(ea, eb) - gray_pos(m_a, m_b) + 4) % 4;
        if (d == 1) begin cnt = 1; up = 1; end
        if (d == 3) begin cnt = 1; up = 0; end
      end
      2'd1: begin
        cnt = g_rise ? (!m_a && ea) : (m_a != ea);
        up  = eb;
      end
      2'd2: begin cnt = !m_a && ea; up = 1; end
      default: begin cnt = !m_a && ea; up = 0; end
    endcase
    if (cnt) m_dir = up;
    q.push_back('{cyc + 3, cnt, m_dir, i ^ g_inv_idx, s ^ g_inv_stb, req});
    m_a = ea; m_b = eb;
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) drive(c_a, c_b, c_i, c_s, req);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic check_err(input logic exp, input string req);
    @(negedge clk);
    n_chk++;
    if (phase_err !== exp) begin
      n_bad++;
      $display("FAIL %s phase_err actual=%0b expected=%0b", req, phase_err, exp);
    end
  endtask

  // Monitor: pops the expected item due in this cycle.
  always @(negedge clk) begin
    if (q.size() != 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (count_en !== e.cnt || dir !== e.up || idx_out !== e.idx ||
          stb_out !== e.stb) begin
        n_bad++;
        $display("FAIL %s cyc=%0d actual cnt/dir/idx/stb=%0b%0b%0b%0b expected=%0b%0b%0b%0b",
                 e.req, cyc, count_en, dir, idx_out, stb_out,
                 e.cnt, e.up, e.idx, e.stb);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (count_en !== 0 || dir !== 1 || phase_err !== 0 || idx_out !== 0 || stb_out !== 0) begin
      n_bad++;
      $display("FAIL R11 reset outputs actual=%0b%0b%0b%0b%0b expected=01000",
               count_en, dir, phase_err, idx_out, stb_out);
    end
    rst_n = 1'b1;
    idle(3, "R11");

    // R1 R2: quadrature, A leading then B leading
    drive(1, 0, 0, 0, "R2"); drive(1, 1, 0, 0, "R2");
    drive(0, 1, 0, 0, "R2"); drive(0, 0, 0, 0, "R2");
    drive(0, 1, 0, 0, "R2"); drive(1, 1, 0, 0, "R2");
    drive(1, 0, 0, 0, "R2"); drive(0, 0, 0, 0, "R2");
    idle(3, "R12");
    drive(1, 0, 0, 0, "R2"); idle(3, "R12");
    drive(0, 0, 0, 0, "R2"); idle(3, "R12");

    // R9: swap reverses quadrature direction
    g_swap = 1;
    drive(1, 0, 0, 0, "R9"); drive(1, 1, 0, 0, "R9");
    drive(0, 1, 0, 0, "R9"); drive(0, 0, 0, 0, "R9");
    g_swap = 0; idle(3, "R9");

    // R8: inverting A looks like an A edge
    g_inv_a = 1; drive(0, 0, 0, 0, "R8");
    g_inv_a = 0; drive(0, 0, 0, 0, "R8");
    g_inv_b = 1; drive(0, 0, 0, 0, "R8");
    g_inv_b = 0; drive(0, 0, 0, 0, "R8");
    idle(4, "R8");
    drain();

    // R3: both channels change together
    check_err(0, "R3");
    drive(1, 1, 0, 0, "R3"); idle(4, "R3");
    drain();
    check_err(1, "R3");
    repeat (3) @(negedge clk);
    check_err(1, "R3");
    @(negedge clk) err_clr = 1;
    @(negedge clk) err_clr = 0;
    check_err(0, "R3");
    drive(0, 1, 0, 0, "R3"); drive(0, 0, 0, 0, "R3");
    idle(4, "R3");

    // R4: clock-plus-direction, both edges
    g_mode = 2'd1;
    drive(0, 1, 0, 0, "R4"); drive(1, 1, 0, 0, "R4");
    drive(0, 1, 0, 0, "R4"); drive(0, 0, 0, 0, "R4");
    drive(1, 0, 0, 0, "R4"); drive(0, 0, 0, 0, "R4");
    idle(4, "R4");
    // R5: rising edges only
    g_rise = 1;
    drive(0, 1, 0, 0, "R5"); drive(1, 1, 0, 0, "R5");
    drive(0, 1, 0, 0, "R5"); drive(1, 0, 0, 0, "R5");
    drive(0, 0, 0, 0, "R5");
    idle(4, "R5");
    g_rise = 0;

    // R6: up mode, B ignored
    g_mode = 2'd2;
    drive(0, 1, 0, 0, "R6"); drive(1, 1, 0, 0, "R6");
    drive(1, 0, 0, 0, "R6"); drive(0, 0, 0, 0, "R6");
    drive(1, 0, 0, 0, "R6"); drive(0, 1, 0, 0, "R6");
    idle(4, "R6");

    // R7: down mode
    g_mode = 2'd3;
    drive(0, 0, 0, 0, "R7"); drive(1, 0, 0, 0, "R7");
    drive(1, 1, 0, 0, "R7"); drive(0, 1, 0, 0, "R7");
    drive(1, 1, 0, 0, "R7");
    idle(4, "R7");

    // R10 R8: index/strobe pass-through with inversion
    g_mode = 2'd0;
    drive(1, 1, 1, 0, "R10"); drive(1, 1, 0, 1, "R10");
    drive(1, 1, 1, 1, "R10");
    g_inv_idx = 1; drive(1, 1, 1, 1, "R8");
    g_inv_stb = 1; drive(1, 1, 0, 1, "R8");
    g_inv_idx = 0; g_inv_stb = 0;
    drive(1, 1, 0, 0, "R10");
    idle(4, "R10");
    drain();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule